// File: doc/BRIEF.md
# Serial CRC-4 Frame Checker

This block sits on the receive side of a serial link. A frame arrives one bit at a time as message bits followed by four check bits. The block divides the whole frame by the generator x^4 + x^3 + 1 in a four-stage remainder register. It also rebuilds the message bytes in a shift register. When the frame-end marker arrives, the block reports in the next cycle whether the final remainder is zero, and then clears itself for the next frame.

A bit counts only in a cycle where its valid strobe is high. The last bit of a frame may arrive in the same cycle as the frame-end marker, or the marker may come on its own in a later cycle. The block keeps the four newest bits back from the byte output. Because of this, a check bit never appears on the byte output, and the block does not need to know the frame length in advance.

Top module: `crc4_frame_check`

## Requirements
- R1: While reset is active, byte_vld, byte_out, result_vld and result_ok are all 0.
- R2: The 12-bit frame 111001100110, first bit sent first, passes: result_vld and result_ok are both 1 in the cycle after frame_end.
- R3: result_ok is 1 only when the frame's bit sequence, read as a polynomial with the first bit as the highest power, leaves remainder zero when divided by x^4 + x^3 + 1 (binary 11001). An empty frame passes. result_ok is 0 whenever result_vld is 0.
- R4: Inverting any single bit of a valid frame makes the frame fail.
- R5: A valid frame fails when two of its bits fewer than 15 positions apart are inverted, or when any burst of up to four adjacent bits is inverted.
- R6: result_vld is high for exactly the cycle after each cycle in which frame_end is high. A bit presented with bit_vld in the frame_end cycle belongs to the ending frame.
- R7: The remainder restarts from zero after each frame end, so the verdict on a frame does not depend on earlier frames.
- R8: The k-th byte (k = 0, 1, ...) is frame bits 8k+1 to 8k+8, with the earlier bit in the higher bit position. It is presented with byte_vld high for one cycle. That cycle is the one after the frame's (8k+12)-th valid bit is accepted.
- R9: The last four bits of a frame are never output. A trailing group of fewer than eight message bits is dropped. byte_vld stays low in every other cycle.
- R10: When the bit that completes a byte arrives together with frame_end, the byte strobe and the result pulse are both high in the same next cycle.
- R11: A cycle with bit_vld low leaves the remainder, the byte assembly and the bit count unchanged, whatever value bit_in has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | bit_in is valid this cycle |
| frame_end | input | 1 | Current frame ends this cycle |
| byte_out | output | 8 | Reassembled message byte, earliest bit in the most significant bit |
| byte_vld | output | 1 | byte_out holds a new byte |
| result_vld | output | 1 | One-cycle verdict pulse |
| result_ok | output | 1 | Final remainder was zero (valid with result_vld) |

## Verification
The byte strobe and the verdict pulse can fall in the same cycle. This happens when the bit that completes a message byte also carries the frame-end marker, for example a frame with an 8-bit message where frame_end rides on the last check bit. The bench builds that case directly, and the random frames also produce it whenever the message length is a multiple of eight and the marker is sent with the last bit. In that cycle the bench checks the emitted byte and the verdict separately against its own model. It also checks that the next frame starts with both a clean remainder and a clean byte count.

// File: rtl/crc4_frame_check.sv
`timescale 1ns/1ps
module crc4_frame_check #(
  parameter int BYTE_W = 8,
  parameter int CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              frame_end,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              result_vld,
  output logic              result_ok
);
  localparam int SR_W  = BYTE_W + CRC_W;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic [CRC_W-1:0] rem_q, rem_d;
  logic [SR_W-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q;
  logic             fb, full;

  assign fb    = bit_in ^ rem_q[CRC_W-1];
  assign rem_d = bit_vld ? ({rem_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0)) : rem_q;
  assign sr_d  = {sr_q[SR_W-2:0], bit_in};
  assign full  = bit_vld && (cnt_q == CNT_W'(SR_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      sr_q       <= '0;
      cnt_q      <= '0;
      byte_out   <= '0;
      byte_vld   <= 1'b0;
      result_vld <= 1'b0;
      result_ok  <= 1'b0;
    end else begin
      byte_vld   <= full;
      result_vld <= frame_end;
      result_ok  <= frame_end && (rem_d == '0);
      rem_q      <= frame_end ? '0 : rem_d;
      if (full)
        byte_out <= sr_d[SR_W-1:CRC_W];
      if (bit_vld)
        sr_q <= sr_d;
      if (frame_end)
        cnt_q <= '0;
      else if (full)
        cnt_q <= CNT_W'(CRC_W);
      else if (bit_vld)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/crc4_frame_check_props.sv
`timescale 1ns/1ps
module crc4_frame_check_props (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic frame_end,
  input logic byte_vld,
  input logic result_vld,
  input logic result_ok
);
  p_pulse_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> result_vld);
  p_pulse_needs_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> $past(frame_end));
  p_ok_inside_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_ok |-> result_vld);
  p_byte_needs_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(bit_vld));
  p_byte_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

bind crc4_frame_check crc4_frame_check_props u_props (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .frame_end(frame_end),
  .byte_vld(byte_vld), .result_vld(result_vld), .result_ok(result_ok)
);

// File: tb/tb_crc4_frame_check.sv
`timescale 1ns/1ps
module tb_crc4_frame_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0, bit_vld = 1'b0, frame_end = 1'b0;
  logic [7:0] byte_out;
  logic       byte_vld, result_vld, result_ok;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit txq[$];
  bit expq[$];

  always #2 clk = ~clk;

  crc4_frame_check dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .frame_end(frame_end), .byte_out(byte_out), .byte_vld(byte_vld),
    .result_vld(result_vld), .result_ok(result_ok)
  );

  function automatic logic [3:0] rem_of(input bit q[$]);
    logic [4:0] r = '0;
    foreach (q[i]) begin
      r = {r[3:0], q[i]};
      if (r[4]) r = r ^ 5'b11001;
    end
    return r[3:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic v, input logic fe, input string rtag);
    logic eb = 1'b0;
    logic [7:0] eby = '0;
    logic eok;
    int n;
    @(negedge clk);
    bit_in = b; bit_vld = v; frame_end = fe;
    if (v) begin
      expq.push_back(b);
      n = expq.size();
      if (n >= 12 && (n - 12) % 8 == 0) begin
        eb = 1'b1;
        for (int i = 0; i < 8; i++) eby[7-i] = expq[n-12+i];
      end
    end
    eok = fe && (rem_of(expq) == 4'd0);
    if (fe) expq.delete();
    @(posedge clk); #1;
    chk(byte_vld == eb, eb ? "R8" : "R9", "byte_vld", byte_vld, eb);
    if (eb) chk(byte_out == eby, "R8", "byte_out", byte_out, eby);
    chk(result_vld == fe, "R6", "result_vld", result_vld, fe);
    chk(result_ok == eok, rtag, "result_ok", result_ok, eok);
  endtask

  task automatic send(input bit fe_sep, input int gap_pct, input string tag);
    for (int i = 0; i < txq.size(); i++) begin
      while (int'($urandom % 100) < gap_pct) cyc(1'($urandom), 1'b0, 1'b0, "R11");
      cyc(txq[i], 1'b1, (i == txq.size() - 1) && !fe_sep, tag);
    end
    if (fe_sep || txq.size() == 0) cyc(1'($urandom), 1'b0, 1'b1, tag);
  endtask

  task automatic make_frame(input int len);
    bit t[$];
    logic [3:0] f;
    txq.delete();
    for (int i = 0; i < len; i++) txq.push_back(1'($urandom));
    t = txq;
    for (int i = 0; i < 4; i++) t.push_back(1'b0);
    f = rem_of(t);
    for (int i = 3; i >= 0; i--) txq.push_back(f[i]);
  endtask

  task automatic golden();
    txq = '{1,1,1,0,0,1,1,0,0,1,1,0};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20071011));
    repeat (3) @(posedge clk);
    #1;
    chk(byte_vld == 0, "R1", "byte_vld", byte_vld, 0);
    chk(byte_out == 0, "R1", "byte_out", byte_out, 0);
    chk(result_vld == 0, "R1", "result_vld", result_vld, 0);
    chk(result_ok == 0, "R1", "result_ok", result_ok, 0);
    @(negedge clk) rst_n = 1'b1;

    golden(); send(1'b0, 0, "R2");
    golden(); send(1'b1, 30, "R2");
    txq.delete(); send(1'b0, 0, "R3");

    for (int p = 0; p < 12; p++) begin
      golden(); txq[p] = ~txq[p]; send(1'b0, 10, "R4");
      golden(); send(1'b0, 0, "R7");
    end
    for (int a = 0; a < 12; a++)
      for (int b = a + 1; b < 12; b++) begin
        golden(); txq[a] = ~txq[a]; txq[b] = ~txq[b]; send(1'b0, 0, "R5");
      end
    for (int w = 2; w <= 4; w++)
      for (int s = 0; s + w <= 12; s++) begin
        golden();
        for (int k = 0; k < w; k++) txq[s+k] = ~txq[s+k];
        send(1'b0, 0, "R5");
      end

    make_frame(8);  send(1'b0, 0, "R10");
    make_frame(16); send(1'b0, 0, "R10");
    make_frame(13); send(1'b1, 20, "R9");
    make_frame(3);  send(1'b0, 0, "R9");
    repeat (6) cyc(1'($urandom), 1'b0, 1'b0, "R11");

    for (int f = 0; f < 300; f++) begin
      int len = int'($urandom % 41);
      int nerr = int'($urandom % 4);
      make_frame(len);
      for (int e = 0; e < nerr; e++) begin
        int p = int'($urandom % txq.size());
        txq[p] = ~txq[p];
      end
      send(1'($urandom), int'($urandom % 40), "R3");
      if ($urandom % 3 == 0) cyc(1'($urandom), 1'b0, 1'b0, "R11");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule